// File: doc/BRIEF.md
# Dual-Cycle Instruction Store Host Port

This block connects a 16-bit host bus to a 128-entry instruction store. Each entry is 20 bits wide: a 16-bit opcode or data word, three control-level bits (W, CM, EC) and one select bit S. S tells a native instruction apart from a CAM instruction. The host reaches an entry through a store window in two bus cycles. The first cycle carries the word and the second carries the four side bits. An address pointer steps to the next entry only once both cycles are done. The host can read and load the pointer through a control register.

The top of the same array doubles as a FIFO that grows downward from 7Fh toward a programmable lower limit. The FIFO has its own read and write pointers and an occupancy count. A single active-low status output reports either "full" or "empty", as chosen by a control bit.

Every host access ends with a one-cycle active-low ready pulse. While a routine instruction is executing (`exec_busy` high), accesses are held off and the pulse is delayed.

Top module: `isq_host_port`

## Requirements
- R1: After reset, `host_rdy_n` is 1, `host_rdata` is 0, the pointer and phase are 0, the flag mode is "full", the FIFO limit is 70h, the FIFO is empty and `status_n` is 1.
- R2: Register select 0 is the store window. A write in phase 0 loads the word field at the pointer. A write in phase 1 loads bits [3:0] as W (bit 0), CM (bit 1), EC (bit 2) and S (bit 3). The pointer increments only after the phase-1 cycle.
- R3: Reads through register select 0 follow the same two phases. Phase 0 returns the word, and phase 1 returns {12'b0, S, EC, CM, W}. The pointer increments after the phase-1 read.
- R4: The pointer wraps from 7Fh to 00h.
- R5: Register select 1 is the control register: bits [6:0] are the pointer, bit 7 the phase (read-only), bit 8 the flag mode (0 = full, 1 = empty). Writing it loads the pointer and mode and clears the phase.
- R6: An access is accepted on a rising edge where `host_sel` is 1, `exec_busy` is 0 and `host_rdy_n` is 1. `host_rdy_n` is then 0 for exactly the next cycle, with the read data valid on `host_rdata`; otherwise `host_rdata` is 0.
- R7: While `exec_busy` is 1 no access is accepted; a held request completes once `exec_busy` falls.
- R8: Register select 3 written pushes a word into the shared array, starting at 7Fh and moving downward, with side bits 0. The pushed word is visible through the store window at its address.
- R9: Register select 3 read pops words in push order. Both FIFO pointers wrap from the limit back to 7Fh.
- R10: A push while full and a pop while empty have no effect on the FIFO; an empty pop returns 0.
- R11: `status_n` is 0 when the FIFO is full (mode 0) or empty (mode 1), else 1.
- R12: Register select 2 holds the 7-bit limit. Writing it sets the depth to 128 minus the limit and empties the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access request |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 store, 1 control, 2 limit, 3 FIFO |
| host_wdata | input | 16 | Host write data |
| exec_busy | input | 1 | A routine instruction is executing |
| host_rdata | output | 16 | Read data, valid while `host_rdy_n` is 0 |
| host_rdy_n | output | 1 | Active-low ready pulse |
| status_n | output | 1 | Active-low FIFO full or empty flag |

## Verification
Store traffic is run as write-then-read sweeps across several entries, with control-register reads placed between the two phases. This separates a pointer that steps after the first cycle from one that steps after the second. A pointer load to 7Fh exposes the wrap. A small-depth FIFO is filled past capacity, partly drained, refilled across the wrap and then drained past empty. This sequence tells apart correct wrap at the limit, ignored overflow and zero-returning underflow under both flag modes. Held requests, against a raised `exec_busy` and across the ready cycle, show whether acceptance waits for both the executing instruction and the end of the previous handshake.

// File: rtl/isq_pkg.sv
package isq_pkg;
   typedef enum logic [1:0] {
      SEL_STORE = 2'd0,
      SEL_CTRL  = 2'd1,
      SEL_LIMIT = 2'd2,
      SEL_FIFO  = 2'd3
   } isq_sel_e;
endpackage

// File: rtl/isq_ptr_phase.sv
module isq_ptr_phase #(
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] ptr,
   output logic              phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr   <= '0;
         phase <= 1'b0;
      end else if (load) begin
         ptr   <= load_val;
         phase <= 1'b0;
      end else if (step) begin
         phase <= ~phase;
         if (phase) ptr <= ptr + 1'b1;
      end
   end

   // R2 R3 R4: second cycle advances by one, wrapping modulo the depth
   p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && phase) |=> (ptr == $past(ptr) + 1'b1));
   p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !phase) |=> ($stable(ptr) && phase));
   // R5: a load clears the phase
   p_load_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !phase);
endmodule

// File: rtl/isq_fifo_ctl.sv
module isq_fifo_ctl #(
   parameter int ADDR_W    = 7,
   parameter int LIMIT_RST = 112
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic              lim_we,
   input  logic [ADDR_W-1:0] lim_in,
   output logic [ADDR_W-1:0] limit,
   output logic [ADDR_W-1:0] waddr,
   output logic [ADDR_W-1:0] raddr,
   output logic              full,
   output logic              empty
);
   localparam int CNT_W = ADDR_W + 1;
   localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
   localparam logic [CNT_W-1:0]  DEPTH = CNT_W'(1 << ADDR_W);

   logic [CNT_W-1:0] count;
   logic [CNT_W-1:0] depth;

   assign depth = DEPTH - {1'b0, limit};
   assign full  = (count == depth);
   assign empty = (count == '0);

   function automatic logic [ADDR_W-1:0] nxt(input logic [ADDR_W-1:0] p,
                                              input logic [ADDR_W-1:0] lim);
      return (p == lim) ? TOP : p - 1'b1;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit <= ADDR_W'(LIMIT_RST);
         waddr <= TOP;
         raddr <= TOP;
         count <= '0;
      end else if (lim_we) begin
         limit <= lim_in;
         waddr <= TOP;
         raddr <= TOP;
         count <= '0;
      end else if (push && !full) begin
         waddr <= nxt(waddr, limit);
         count <= count + 1'b1;
      end else if (pop && !empty) begin
         raddr <= nxt(raddr, limit);
         count <= count - 1'b1;
      end
   end

   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      count <= depth);
   p_full_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !lim_we) |=> ($stable(count) && $stable(waddr)));
   p_empty_pop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !lim_we) |=> ($stable(count) && $stable(raddr)));
   p_limit_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      lim_we |=> (empty && waddr == TOP && raddr == TOP));
endmodule

// File: rtl/isq_store.sv
module isq_store #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 16,
   parameter int CTL_W  = 4
) (
   input  logic              clk,
   input  logic              we_data,
   input  logic              we_ctl,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CTL_W-1:0]  wctl,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic [CTL_W-1:0]  rctl
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] word_mem [DEPTH];
   logic [CTL_W-1:0]  side_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_data) word_mem[waddr] <= wdata;
      if (we_ctl)  side_mem[waddr] <= wctl;
   end

   assign rdata = word_mem[raddr];
   assign rctl  = side_mem[raddr];
endmodule

// File: rtl/isq_host_port.sv
module isq_host_port
   import isq_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int DATA_W     = 16,
   parameter int CTL_W      = 4,
   parameter int HOST_W     = 16,
   parameter int LIMIT_RST  = 112,
   parameter bit STATUS_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_sel,
   input  logic              host_wr,
   input  logic [1:0]        host_reg,
   input  logic [HOST_W-1:0] host_wdata,
   input  logic              exec_busy,
   output logic [HOST_W-1:0] host_rdata,
   output logic              host_rdy_n,
   output logic              status_n
);
   localparam int PH_BIT   = ADDR_W;
   localparam int MODE_BIT = ADDR_W + 1;

   if (HOST_W < DATA_W || HOST_W < MODE_BIT + 1 || HOST_W < CTL_W) begin : g_bad_width
      $error("isq_host_port: host bus too narrow for fields");
   end
   if (LIMIT_RST < 0 || LIMIT_RST >= (1 << ADDR_W)) begin : g_bad_limit
      $error("isq_host_port: reset limit out of range");
   end

   isq_sel_e          sel;
   logic              accept, acc_store, st_wd, st_wc, push_ok, pop_req;
   logic              ctrl_we, lim_we, mode_q, flag_c, rdy_n_q;
   logic [ADDR_W-1:0] ptr, limit, f_waddr, f_raddr, mem_waddr, mem_raddr;
   logic              phase, full, empty;
   logic [DATA_W-1:0] m_word;
   logic [CTL_W-1:0]  m_side, wside;
   logic [HOST_W-1:0] rd_value, rdata_q;

   assign sel       = isq_sel_e'(host_reg);
   assign accept    = host_sel & ~exec_busy & rdy_n_q;
   assign acc_store = accept & (sel == SEL_STORE);
   assign st_wd     = acc_store & host_wr & ~phase;
   assign st_wc     = acc_store & host_wr & phase;
   assign ctrl_we   = accept & host_wr & (sel == SEL_CTRL);
   assign lim_we    = accept & host_wr & (sel == SEL_LIMIT);
   assign push_ok   = accept & host_wr & (sel == SEL_FIFO) & ~full;
   assign pop_req   = accept & ~host_wr & (sel == SEL_FIFO);

   assign mem_waddr = push_ok ? f_waddr : ptr;
   assign mem_raddr = (sel == SEL_FIFO) ? f_raddr : ptr;
   assign wside     = push_ok ? '0 : host_wdata[CTL_W-1:0];

   isq_ptr_phase #(.ADDR_W(ADDR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .step(acc_store), .load(ctrl_we),
      .load_val(host_wdata[ADDR_W-1:0]), .ptr(ptr), .phase(phase));

   isq_fifo_ctl #(.ADDR_W(ADDR_W), .LIMIT_RST(LIMIT_RST)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_req),
      .lim_we(lim_we), .lim_in(host_wdata[ADDR_W-1:0]), .limit(limit),
      .waddr(f_waddr), .raddr(f_raddr), .full(full), .empty(empty));

   isq_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTL_W(CTL_W)) u_store (
      .clk(clk), .we_data(st_wd | push_ok), .we_ctl(st_wc | push_ok),
      .waddr(mem_waddr), .wdata(host_wdata[DATA_W-1:0]), .wctl(wside),
      .raddr(mem_raddr), .rdata(m_word), .rctl(m_side));

   always_comb begin
      rd_value = '0;
      unique case (sel)
         SEL_STORE: if (phase) rd_value[CTL_W-1:0] = m_side;
                    else       rd_value[DATA_W-1:0] = m_word;
         SEL_CTRL: begin
            rd_value[ADDR_W-1:0] = ptr;
            rd_value[PH_BIT]     = phase;
            rd_value[MODE_BIT]   = mode_q;
         end
         SEL_LIMIT: rd_value[ADDR_W-1:0] = limit;
         SEL_FIFO:  if (!empty) rd_value[DATA_W-1:0] = m_word;
         default:   rd_value = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdy_n_q <= 1'b1;
         rdata_q <= '0;
         mode_q  <= 1'b0;
      end else begin
         rdy_n_q <= ~accept;
         rdata_q <= (accept & ~host_wr) ? rd_value : '0;
         if (ctrl_we) mode_q <= host_wdata[MODE_BIT];
      end
   end

   assign flag_c     = mode_q ? empty : full;
   assign host_rdy_n = rdy_n_q;
   assign host_rdata = rdata_q;

   if (STATUS_REG) begin : g_status_reg
      logic stat_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q <= 1'b1;
         else        stat_q <= ~flag_c;
      end
      assign status_n = stat_q;
   end else begin : g_status_comb
      assign status_n = ~flag_c;
   end

   p_ack_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rdy_n |=> host_rdy_n);
   p_ack_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !host_rdy_n |-> $past(host_sel && !exec_busy));
   p_idle_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
      host_rdy_n |-> (host_rdata == '0));
endmodule

// File: tb/isq_host_port_bench.sv
module isq_host_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_sel = 1'b0, host_wr = 1'b0, exec_busy = 1'b0;
   logic [1:0]  host_reg = 2'd0;
   logic [15:0] host_wdata = 16'd0;
   logic [15:0] host_rdata;
   logic        host_rdy_n, status_n;

   int n_cmp = 0, n_bad = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   isq_host_port u_isq_host_port (
      .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
      .host_reg(host_reg), .host_wdata(host_wdata), .exec_busy(exec_busy),
      .host_rdata(host_rdata), .host_rdy_n(host_rdy_n), .status_n(status_n));

   // behavioural reference
   bit [15:0] ref_word [128];
   bit [3:0]  ref_side [128];
   int        ref_q[$];
   int        ref_ptr, ref_phase, ref_mode, ref_lim, ref_wa, ref_ra;
   bit        ref_rdy_n = 1'b1;
   bit [15:0] ref_rdata;

   function automatic int step_down(int p, int lim);
      return (p == lim) ? 127 : p - 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_ptr = 0; ref_phase = 0; ref_mode = 0; ref_lim = 112;
         ref_wa = 127; ref_ra = 127; ref_q.delete();
         ref_rdy_n = 1'b1; ref_rdata = 16'd0;
      end else begin
         bit acc;
         acc = host_sel && !exec_busy && ref_rdy_n;
         ref_rdy_n = !acc;
         ref_rdata = 16'd0;
         if (acc) begin
            case (host_reg)
               2'd0: begin
                  if (host_wr) begin
                     if (ref_phase == 0) ref_word[ref_ptr] = host_wdata;
                     else                ref_side[ref_ptr] = host_wdata[3:0];
                  end else begin
                     ref_rdata = (ref_phase == 0) ? ref_word[ref_ptr]
                                                  : {12'd0, ref_side[ref_ptr]};
                  end
                  if (ref_phase == 1) ref_ptr = (ref_ptr + 1) % 128;
                  ref_phase = 1 - ref_phase;
               end
               2'd1: begin
                  if (host_wr) begin
                     ref_ptr = host_wdata[6:0]; ref_mode = host_wdata[8]; ref_phase = 0;
                  end else ref_rdata = 16'(ref_ptr + ref_phase * 128 + ref_mode * 256);
               end
               2'd2: begin
                  if (host_wr) begin
                     ref_lim = host_wdata[6:0]; ref_q.delete(); ref_wa = 127; ref_ra = 127;
                  end else ref_rdata = 16'(ref_lim);
               end
               default: begin
                  if (host_wr) begin
                     if (ref_q.size() < 128 - ref_lim) begin
                        ref_q.push_back(host_wdata);
                        ref_word[ref_wa] = host_wdata; ref_side[ref_wa] = 4'd0;
                        ref_wa = step_down(ref_wa, ref_lim);
                     end
                  end else if (ref_q.size() > 0) begin
                     ref_rdata = 16'(ref_q.pop_front());
                     ref_ra = step_down(ref_ra, ref_lim);
                  end
               end
            endcase
         end
      end
   end

   function automatic bit ref_status_n();
      if (ref_mode == 1) return !(ref_q.size() == 0);
      return !(ref_q.size() == 128 - ref_lim);
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         n_cmp++;
         if (host_rdy_n !== ref_rdy_n || host_rdata !== ref_rdata ||
             status_n !== ref_status_n()) begin
            n_bad++;
            $display("FAIL %s: rdy_n/rdata/status_n = %b/%h/%b expected %b/%h/%b", cur_req,
                     host_rdy_n, host_rdata, status_n, ref_rdy_n, ref_rdata, ref_status_n());
         end
      end
   end

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic acc(input logic [1:0] r, input logic w, input logic [15:0] d,
                      output logic [15:0] q);
      @(negedge clk);
      host_sel = 1'b1; host_reg = r; host_wr = w; host_wdata = d;
      do @(negedge clk); while (host_rdy_n);
      q = host_rdata;
      host_sel = 1'b0; host_wr = 1'b0;
   endtask

   logic [15:0] q;

   initial begin
      #1000000;
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cur_req = "R1";
      chk("R1", {14'd0, host_rdy_n, status_n}, 16'h0003);
      chk("R1", host_rdata, 16'h0000);
      rst_n = 1'b1;
      acc(2'd1, 1'b0, 16'd0, q); chk("R1", q, 16'h0000);
      acc(2'd2, 1'b0, 16'd0, q); chk("R1", q, 16'h0070);

      cur_req = "R2";
      for (int i = 0; i < 4; i++) begin
         acc(2'd0, 1'b1, 16'hA100 + 16'(i), q);
         acc(2'd1, 1'b0, 16'd0, q); chk("R2", q, 16'h0080 + 16'(i));
         acc(2'd0, 1'b1, 16'(i + 9), q);
      end
      acc(2'd1, 1'b0, 16'd0, q); chk("R2", q, 16'h0004);

      cur_req = "R3";
      acc(2'd1, 1'b1, 16'd0, q);
      for (int i = 0; i < 4; i++) begin
         acc(2'd0, 1'b0, 16'd0, q); chk("R3", q, 16'hA100 + 16'(i));
         acc(2'd0, 1'b0, 16'd0, q); chk("R3", q, 16'(i + 9) & 16'h000F);
      end

      cur_req = "R4";
      acc(2'd1, 1'b1, 16'h007F, q);
      acc(2'd0, 1'b1, 16'h5A5A, q);
      acc(2'd0, 1'b1, 16'h0006, q);
      acc(2'd1, 1'b0, 16'd0, q); chk("R4", q, 16'h0000);

      cur_req = "R5";
      acc(2'd0, 1'b1, 16'h1111, q);
      acc(2'd1, 1'b1, 16'h0105, q);
      acc(2'd1, 1'b0, 16'd0, q); chk("R5", q, 16'h0105);
      acc(2'd1, 1'b1, 16'h0000, q);

      cur_req = "R7";
      exec_busy = 1'b1;
      fork
         acc(2'd2, 1'b0, 16'd0, q);
         begin
            repeat (6) @(negedge clk);
            chk("R7", {15'd0, host_rdy_n}, 16'h0001);
            exec_busy = 1'b0;
         end
      join
      chk("R7", q, 16'h0070);

      cur_req = "R6";
      @(negedge clk);
      host_sel = 1'b1; host_reg = 2'd1; host_wr = 1'b0;
      repeat (5) @(negedge clk);
      host_sel = 1'b0;
      repeat (2) @(negedge clk);

      cur_req = "R12";
      acc(2'd3, 1'b1, 16'hDEAD, q);
      acc(2'd2, 1'b1, 16'h007C, q);
      acc(2'd3, 1'b0, 16'd0, q); chk("R12", q, 16'h0000);

      cur_req = "R8";
      for (int i = 0; i < 5; i++) acc(2'd3, 1'b1, 16'hC000 + 16'(i), q);
      chk("R11", {15'd0, status_n}, 16'h0000);
      acc(2'd1, 1'b1, 16'h007F, q);
      acc(2'd0, 1'b0, 16'd0, q); chk("R8", q, 16'hC000);
      acc(2'd0, 1'b0, 16'd0, q); chk("R8", q, 16'h0000);
      acc(2'd1, 1'b1, 16'h007C, q);
      acc(2'd0, 1'b0, 16'd0, q); chk("R10", q, 16'hC003);

      cur_req = "R9";
      acc(2'd3, 1'b0, 16'd0, q); chk("R9", q, 16'hC000);
      acc(2'd3, 1'b0, 16'd0, q); chk("R9", q, 16'hC001);
      acc(2'd3, 1'b1, 16'hD000, q);
      acc(2'd3, 1'b1, 16'hD001, q);
      acc(2'd3, 1'b0, 16'd0, q); chk("R9", q, 16'hC002);
      acc(2'd3, 1'b0, 16'd0, q); chk("R9", q, 16'hC003);
      acc(2'd3, 1'b0, 16'd0, q); chk("R9", q, 16'hD000);
      acc(2'd3, 1'b0, 16'd0, q); chk("R9", q, 16'hD001);

      cur_req = "R10";
      acc(2'd3, 1'b0, 16'd0, q); chk("R10", q, 16'h0000);

      cur_req = "R11";
      chk("R11", {15'd0, status_n}, 16'h0001);
      acc(2'd1, 1'b1, 16'h0100, q);
      @(negedge clk); chk("R11", {15'd0, status_n}, 16'h0000);
      acc(2'd3, 1'b1, 16'hBEEF, q);
      @(negedge clk); chk("R11", {15'd0, status_n}, 16'h0001);
      cur_req = "R12";
      acc(2'd2, 1'b1, 16'h0070, q);
      @(negedge clk); chk("R12", {15'd0, status_n}, 16'h0000);

      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule